// File: doc/BRIEF.md
# Self-Adjusting Input-Port Cell Scheduler

This block sits in one input port of a crossbar whose output columns act as reconfigurable buses. If two ports send to the same column, the port further downstream catches the upstream cell. Once per time slot the block decides which cell its port sends into the fabric. There are two candidates. The first is the oldest cell in a small queue of cells caught from upstream ports. The second is the head cell of one of the port's virtual output queues, chosen by a round-robin pointer. The block uses only local state and never exchanges signals with other ports. Cell payloads are held outside the block. The block tracks the destination column of each caught cell and reads one occupancy bit per virtual output queue.

A caught cell always goes first. It is resent in the slot after it was caught, so it leaves ahead of later cells of the same flow. When there is no caught cell, the pointer searches forward from its current position and stops on the first occupied queue. Once the handshake completes, the pointer moves in one of two ways. If the cell crossed the fabric, the pointer steps one column past it. If a downstream port caught the cell, the pointer stays on that column. Over time this drifts the pointers of different ports apart.

The transmit side is a valid/ready stream. `tx_valid`, `tx_col` and `tx_from_uq` are a combinational function of the pointer, the caught-cell queue and `voq_nonempty`. While `tx_ready` is low, nothing inside the block changes except through an intercept write, and the request stays steady as long as `voq_nonempty` does. A transfer happens on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_lost` is sampled only on such an edge. The intercept write port cannot be held back, because the fabric cannot stall. A write that finds the queue full is dropped and reported on `uq_overflow`.

Top module: `sa_input_sched`

## Requirements
- R1: While reset is asserted, and right after it, `rr_ptr` is 0, the caught-cell queue is empty and `uq_overflow` is 0. With `voq_nonempty` all zero, `tx_valid` is 0.
- R2: While the caught-cell queue holds a cell, `tx_valid` is 1, `tx_from_uq` is 1 and `tx_col` is the column of its oldest entry, whatever `voq_nonempty` holds.
- R3: Caught cells are offered in the order they were written.
- R4: With the caught-cell queue empty, `tx_col` is the first index at or above `rr_ptr`, wrapping from N_PORTS-1 to 0, whose `voq_nonempty` bit is 1, and `tx_from_uq` is 0.
- R5: With no caught cell and `voq_nonempty` all zero, `tx_valid` is 0 and `rr_ptr` keeps its value.
- R6: After a transfer from the caught-cell queue, `rr_ptr` equals that cell's column and the entry is removed.
- R7: After a transfer from virtual output queue j with `tx_lost` low, `rr_ptr` equals (j+1) mod N_PORTS.
- R8: After a transfer from virtual output queue j with `tx_lost` high, `rr_ptr` equals j.
- R9: On an edge without a transfer, `rr_ptr` and the queue contents do not change, and `tx_lost` has no effect.
- R10: A cell written through `up_wr` on one edge is offered, with `tx_from_uq` high, in the very next cycle.
- R11: A write that finds the queue full, with no transfer from the queue on the same edge, is dropped, and `uq_overflow` is 1 for exactly the following cycle. A write that meets a full queue on the same edge as a transfer from the queue is accepted and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| voq_nonempty | input | N_PORTS | Bit j set when virtual output queue j holds a cell |
| up_wr | input | 1 | A cell from upstream was caught and is written this edge |
| up_col | input | COL_W | Destination column of the caught cell |
| tx_valid | output | 1 | A cell is offered to the fabric |
| tx_ready | input | 1 | The fabric takes the offered cell this edge |
| tx_col | output | COL_W | Destination column of the offered cell |
| tx_from_uq | output | 1 | 1: cell comes from the caught-cell queue; 0: from virtual output queue `tx_col` |
| tx_lost | input | 1 | With a transfer: the sent cell was caught downstream |
| rr_ptr | output | COL_W | Round-robin pointer |
| uq_overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
The request outputs are combinational, so they are due in the same cycle as the inputs that produce them. `rr_ptr`, queue removal and `uq_overflow` change on the edge that ends the cycle of the handshake or write. A caught cell written on an edge appears as the request one cycle later. The driver applies each cycle's inputs just after a rising edge and queues the outputs it expects for that cycle, computed from the state that edge left behind. The monitor compares them at the following falling edge, and only then does the driver's model advance across the next rising edge.

// File: rtl/sa_sched_pkg.sv
package sa_sched_pkg;

  typedef enum logic {
    SRC_VOQ = 1'b0,
    SRC_UQ  = 1'b1
  } src_e;

endpackage

// File: rtl/sa_rr_search.sv
// Finds the first requesting queue at or after a start index, wrapping.
module sa_rr_search #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         hit,
  output logic [W-1:0] idx
);

  localparam logic [W:0] N_EXT = (W+1)'(N);

  logic [W-1:0] cand [N];
  logic [N-1:0] hitv;

  // Candidate index for every offset from the start position.
  for (genvar g = 0; g < N; g++) begin : g_off
    logic [W:0] sum;
    assign sum     = {1'b0, start} + (W+1)'(g);
    assign cand[g] = (sum >= N_EXT) ? W'(sum - N_EXT) : sum[W-1:0];
    assign hitv[g] = req[cand[g]];
  end

  // Smallest offset wins.
  always_comb begin
    hit = 1'b0;
    idx = start;
    for (int k = N - 1; k >= 0; k--) begin
      if (hitv[k]) begin
        hit = 1'b1;
        idx = cand[k];
      end
    end
  end

endmodule

// File: rtl/sa_uq_fifo.sv
// Column tags of cells caught from upstream ports. Pop is ordered before
// push within a slot, so a full queue popped on the same edge accepts a write.
module sa_uq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         drop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign head    = mem[rd_p];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
      if (do_push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

endmodule

// File: rtl/sa_input_sched.sv
module sa_input_sched #(
  parameter  int N_PORTS  = 8,
  parameter  int UQ_DEPTH = 4,
  localparam int COL_W    = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] voq_nonempty,
  input  logic               up_wr,
  input  logic [COL_W-1:0]   up_col,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [COL_W-1:0]   tx_col,
  output logic               tx_from_uq,
  input  logic               tx_lost,
  output logic [COL_W-1:0]   rr_ptr,
  output logic               uq_overflow
);
  import sa_sched_pkg::*;

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(N_PORTS - 1);

  logic [COL_W-1:0] ptr_q, ptr_d;
  logic [COL_W-1:0] uq_head, voq_idx;
  logic             uq_empty, uq_full, uq_drop, uq_pop;
  logic             voq_hit, fire;
  logic             ovf_q;
  src_e             src;

  sa_uq_fifo #(.DEPTH(UQ_DEPTH), .W(COL_W)) i_uq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (up_wr),
    .din   (up_col),
    .pop   (uq_pop),
    .head  (uq_head),
    .empty (uq_empty),
    .full  (uq_full),
    .drop  (uq_drop)
  );

  sa_rr_search #(.N(N_PORTS), .W(COL_W)) i_search (
    .req   (voq_nonempty),
    .start (ptr_q),
    .hit   (voq_hit),
    .idx   (voq_idx)
  );

  // Selection: caught cell first, otherwise the round-robin search.
  assign src        = uq_empty ? SRC_VOQ : SRC_UQ;
  assign tx_valid   = (src == SRC_UQ) || voq_hit;
  assign tx_col     = (src == SRC_UQ) ? uq_head : voq_idx;
  assign tx_from_uq = (src == SRC_UQ);
  assign fire       = tx_valid && tx_ready;
  assign uq_pop     = fire && (src == SRC_UQ);

  // Pointer update happens only on a completed transfer.
  always_comb begin
    ptr_d = ptr_q;
    if (fire) begin
      if (src == SRC_UQ)  ptr_d = uq_head;
      else if (tx_lost)   ptr_d = voq_idx;
      else                ptr_d = (voq_idx == LAST_COL) ? '0 : voq_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      ovf_q <= uq_drop;
    end
  end

  assign rr_ptr      = ptr_q;
  assign uq_overflow = ovf_q;

endmodule

// File: rtl/sa_input_sched_chk.sv
module sa_input_sched_chk #(
  parameter int N_PORTS = 8,
  parameter int COL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] voq_nonempty,
  input logic               up_wr,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [COL_W-1:0]   tx_col,
  input logic               tx_from_uq,
  input logic               tx_lost,
  input logic [COL_W-1:0]   rr_ptr,
  input logic               uq_overflow,
  input logic               uq_full,
  input logic               uq_pop
);

  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c);
    return (c == COL_W'(N_PORTS - 1)) ? '0 : c + 1'b1;
  endfunction

  // R4: a queue picked by the search must be occupied
  a_r4_pick_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_from_uq |-> voq_nonempty[tx_col]);

  // R5: no request while nothing is queued anywhere
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (voq_nonempty == '0));

  // R6
  a_r6_uq_sets_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_from_uq |=> rr_ptr == $past(tx_col));

  // R7
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !tx_from_uq && !tx_lost
      |=> rr_ptr == step_col($past(tx_col)));

  // R8
  a_r8_hold_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !tx_from_uq && tx_lost |=> rr_ptr == $past(tx_col));

  // R9
  a_r9_no_fire_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready) |=> $stable(rr_ptr));

  // R10
  a_r10_next_slot: assert property (@(posedge clk) disable iff (!rst_n)
    up_wr && !(uq_full && !uq_pop) |=> tx_valid && tx_from_uq);

  // R11
  a_r11_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    up_wr && uq_full && !uq_pop |=> uq_overflow);

  a_r11_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    uq_overflow |-> $past(up_wr));

endmodule

bind sa_input_sched sa_input_sched_chk #(.N_PORTS(N_PORTS), .COL_W(COL_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .voq_nonempty (voq_nonempty),
  .up_wr        (up_wr),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_col       (tx_col),
  .tx_from_uq   (tx_from_uq),
  .tx_lost      (tx_lost),
  .rr_ptr       (rr_ptr),
  .uq_overflow  (uq_overflow),
  .uq_full      (uq_full),
  .uq_pop       (uq_pop)
);

// File: tb/test_sa_input_sched.sv
`timescale 1ns/1ps
module test_sa_input_sched;
  localparam int N = 8;
  localparam int D = 4;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] voq_nonempty;
  logic         up_wr;
  logic [W-1:0] up_col;
  logic         tx_valid, tx_ready, tx_from_uq, tx_lost, uq_overflow;
  logic [W-1:0] tx_col, rr_ptr;

  always #2.5 clk = ~clk;

  sa_input_sched #(.N_PORTS(N), .UQ_DEPTH(D)) i_sa_input_sched (
    .clk(clk), .rst_n(rst_n), .voq_nonempty(voq_nonempty),
    .up_wr(up_wr), .up_col(up_col),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_col(tx_col),
    .tx_from_uq(tx_from_uq), .tx_lost(tx_lost),
    .rr_ptr(rr_ptr), .uq_overflow(uq_overflow)
  );

  typedef struct {
    bit    v;
    bit    fu;
    int    col;
    int    ptr;
    bit    ovf;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Reference state, kept from the requirements.
  int m_ptr = 0;
  int m_q[$];
  bit m_ovf = 0;

  task automatic step(input logic [N-1:0] voq, input bit wr, input int wcol,
                      input bit rdy, input bit lost, input string tag);
    exp_t e;
    bit   found, fire, pop, ovfn;
    int   pick;
    voq_nonempty = voq;
    up_wr        = wr;
    up_col       = W'(wcol);
    tx_ready     = rdy;
    tx_lost      = lost;
    e.tag = tag;
    e.ovf = m_ovf;
    e.ptr = m_ptr;
    if (m_q.size() > 0) begin
      e.v = 1; e.fu = 1; e.col = m_q[0];
    end else begin
      found = 0; pick = 0;
      for (int k = 0; k < N; k++) begin
        int c;
        c = (m_ptr + k) % N;
        if (!found && voq[c]) begin found = 1; pick = c; end
      end
      e.v = found; e.fu = 0; e.col = pick;
    end
    sb.push_back(e);
    @(posedge clk);
    fire = e.v && rdy;
    pop  = fire && e.fu;
    ovfn = wr && (m_q.size() == D) && !pop;
    if (fire) begin
      if (e.fu || lost) m_ptr = e.col;
      else              m_ptr = (e.col + 1) % N;
    end
    if (pop) void'(m_q.pop_front());
    if (wr && !ovfn) m_q.push_back(wcol);
    m_ovf = ovfn;
    #1;
  endtask

  // Monitor: compares at the falling edge.
  exp_t mon_e;
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      bit ok;
      mon_e = sb.pop_front();
      n_vec++;
      ok = (tx_valid === mon_e.v) && (int'(rr_ptr) == mon_e.ptr) &&
           (uq_overflow === mon_e.ovf) &&
           (!mon_e.v || ((tx_from_uq === mon_e.fu) && (int'(tx_col) == mon_e.col)));
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: got v=%0d uq=%0d col=%0d ptr=%0d ovf=%0d exp v=%0d uq=%0d col=%0d ptr=%0d ovf=%0d",
                 mon_e.tag, tx_valid, tx_from_uq, tx_col, rr_ptr, uq_overflow,
                 mon_e.v, mon_e.fu, mon_e.col, mon_e.ptr, mon_e.ovf);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    voq_nonempty = '0; up_wr = 0; up_col = '0; tx_ready = 0; tx_lost = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: state under reset
    n_vec++;
    if (tx_valid !== 1'b0 || rr_ptr !== '0 || uq_overflow !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got v=%0d ptr=%0d ovf=%0d exp v=0 ptr=0 ovf=0",
               tx_valid, rr_ptr, uq_overflow);
    end
    rst_n = 1'b1;
    step(8'h00, 0, 0, 1, 0, "R1");
    step(8'h00, 0, 0, 1, 0, "R5");
    step(8'b0000_1000, 0, 0, 1, 0, "R4");   // col 3, ptr -> 4
    step(8'b0010_0100, 0, 0, 1, 0, "R4");   // col 5 from ptr 4
    step(8'b0010_0100, 0, 0, 1, 0, "R7");   // ptr 6, wraps to col 2
    step(8'b0100_0000, 0, 0, 1, 1, "R8");   // ptr 3 -> col 6, lost
    step(8'b0100_0000, 0, 0, 1, 1, "R8");   // ptr stays 6
    step(8'hFF, 0, 0, 0, 1, "R9");          // lost without handshake
    step(8'hFF, 0, 0, 0, 0, "R9");
    step(8'hFF, 1, 1, 0, 0, "R9");          // caught cell written
    step(8'hFF, 0, 0, 0, 0, "R10");         // offered next cycle
    step(8'hFF, 0, 0, 1, 1, "R2");          // sent, ptr -> 1
    step(8'hFF, 0, 0, 1, 0, "R6");          // ptr now 1
    step(8'h00, 1, 7, 0, 0, "R3");
    step(8'h00, 1, 0, 0, 0, "R3");
    step(8'h00, 1, 3, 0, 0, "R3");
    step(8'h00, 1, 5, 0, 0, "R3");          // queue full
    step(8'h00, 1, 2, 0, 0, "R11");         // dropped
    step(8'h00, 0, 0, 0, 0, "R11");         // flag high
    step(8'h00, 0, 0, 0, 0, "R11");         // flag low again
    step(8'h00, 1, 4, 1, 0, "R11");         // full with pop: accepted
    for (int i = 0; i < 5; i++) step(8'h00, 0, 0, 1, 0, "R3");
    step(8'h00, 0, 0, 1, 0, "R5");
    step(8'h00, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] v;
      v = N'($urandom) & N'($urandom);
      step(v, ($urandom % 4) == 0, int'($urandom % N), ($urandom % 4) != 0,
           ($urandom % 3) == 0, "R4");
    end
    step(8'h00, 0, 0, 0, 0, "R9");
    @(negedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule